// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A producer hands bytes in over a valid/ready stream. The bytes wait in a small queue in front of a shift engine, and the engine sends them one frame at a time. Bit timing comes from an external clock-enable pulse, `tick16`, which pulses sixteen times per bit period. The baud divider that makes this pulse is not part of the block.

The character length, parity mode and stop length are plain control inputs. They can change at any time, and each frame captures them at the moment it leaves the queue. A break request forces the line low. While it is held, no queued byte is started, so the queue keeps its contents until the break ends. The outputs `busy` and `fifo_empty` are plain status pins, and `fifo_empty` can drive an interrupt that asks for more data.

The input stream follows these rules. A byte is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` goes low only when the queue holds all of its entries. This stream does not stall: a byte offered while `in_ready` is low is thrown away, and `overflow` is set and stays set until reset. A producer that must not lose data waits for `in_ready` before it raises `in_valid`.

Top module: `serial_tx_engine`

## Requirements
- R1: Out of reset the line is high, `busy` is low, `fifo_empty` and `in_ready` are high, and `overflow` is low. With no frame in progress and no break, the line stays high.
- R2: A frame starts with one low start bit, followed by the data bits, least significant bit first. The start bit, each data bit and the parity bit each last exactly 16 `tick16` pulses, and the frame does not advance on cycles without a pulse.
- R3: `char_len` selects the number of data bits: code 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Upper bits of the byte beyond the selected length are not sent.
- R4: `parity_mode` code 1 adds a parity bit that makes the count of ones in the data bits plus the parity bit even. Code 2 makes that count odd. Codes 0 and 3 send no parity bit.
- R5: The stop period is high. It lasts 16 pulses when `stop_long` is 0. When `stop_long` is 1, it lasts 24 pulses for 5-bit characters and 32 pulses for 6, 7 or 8 bits.
- R6: The character length, parity mode and stop setting are captured when a frame leaves the queue. Changing them during a frame does not affect that frame.
- R7: The queue holds up to 16 bytes, in the order they were accepted. `in_ready` is low exactly when all 16 entries are in use.
- R8: A byte offered while `in_ready` is low is discarded. `overflow` then rises and stays high until reset.
- R9: While `brk_req` is high, the line is low. No new frame is taken from the queue during a break, and a frame already in progress keeps its timing underneath the break.
- R10: `busy` is high from the clock after a frame leaves the queue until its stop period ends. `fifo_empty` is high exactly when the queue holds no bytes.
- R11: When the queue is not empty, the next frame starts one clock after the previous stop period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Clock-enable pulse at 16 times the bit rate |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Queue has a free entry |
| char_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parity_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| stop_long | input | 1 | 0: one stop bit; 1: one and a half (5-bit) or two |
| brk_req | input | 1 | Hold the line low and pause dequeuing |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is in progress |
| fifo_empty | output | 1 | Queue holds no bytes |
| overflow | output | 1 | Sticky: a byte was offered while the queue was full |

## Verification
Some properties are checked by assertions on every cycle:
- the bit counter stays within one bit period, or within the captured stop length;
- nothing advances without a tick;
- no frame starts while a break is held;
- the captured settings stay frozen during a frame;
- a full queue refuses writes;
- overflow stays set once raised.

Other behaviour only the bench scenarios can show: the serial waveform itself, meaning the bit order, the parity values, the 24-tick versus 32-tick stop periods, and the order of bytes after a write to a full queue. These are covered by comparing every output each cycle against a behavioural model. The model runs across all character lengths, parity modes and stop settings, with changes to the settings mid-frame and with breaks both at idle and mid-frame.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } phase_e;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  // Keep only the low 5..8 bits selected by the length code.
  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic par_enabled(input logic [1:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction

  // Parity bit that makes data+parity even (even mode) or odd (odd mode).
  function automatic logic par_bit(input logic [7:0] masked, input logic [1:0] mode);
    return (mode == PAR_ODD) ? ~(^masked) : (^masked);
  endfunction

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, push;

  assign full       = (count == FULL_CNT);
  assign empty      = (count == '0);
  assign push_ready = ~full;
  assign push       = push_valid & ~full;
  assign head       = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_valid && full) ovf <= 1'b1;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_full_refuses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !pop) |=> (full && $stable(wr_ptr)));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

endmodule

// File: rtl/stx_framer.sv
module stx_framer
  import stx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       brk,
  input  logic [1:0] char_len,
  input  logic [1:0] parity_mode,
  input  logic       stop_long,
  input  logic [7:0] head,
  input  logic       empty,
  output logic       pop,
  output logic       line,
  output logic       busy
);
  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LAST_S1   = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LAST_S15  = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_S2   = CNT_W'(2 * TICKS_PER_BIT - 1);

  phase_e           ph;
  logic [7:0]       sh;
  logic [2:0]       bit_idx;
  logic [2:0]       last_idx_q;
  logic             par_en_q, par_bit_q;
  logic [CNT_W-1:0] tcnt, stop_last_q;
  logic [7:0]       masked;
  logic [CNT_W-1:0] stop_last_d;
  logic             bit_done;

  assign masked   = head & len_mask(char_len);
  assign pop      = (ph == PH_IDLE) && !empty && !brk;
  assign busy     = (ph != PH_IDLE);
  assign bit_done = tick && (tcnt == LAST_BIT);

  always_comb begin
    if (!stop_long)          stop_last_d = LAST_S1;
    else if (char_len == '0) stop_last_d = LAST_S15;
    else                     stop_last_d = LAST_S2;
  end

  always_comb begin
    case (ph)
      PH_START:  line = 1'b0;
      PH_DATA:   line = sh[0];
      PH_PARITY: line = par_bit_q;
      default:   line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      sh          <= '0;
      bit_idx     <= '0;
      last_idx_q  <= '0;
      par_en_q    <= 1'b0;
      par_bit_q   <= 1'b0;
      tcnt        <= '0;
      stop_last_q <= LAST_S1;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (pop) begin
            sh          <= masked;
            last_idx_q  <= 3'd4 + {1'b0, char_len};
            par_en_q    <= par_enabled(parity_mode);
            par_bit_q   <= par_bit(masked, parity_mode);
            stop_last_q <= stop_last_d;
            tcnt        <= '0;
            ph          <= PH_START;
          end
        end
        PH_START: begin
          if (bit_done) begin
            tcnt    <= '0;
            bit_idx <= '0;
            ph      <= PH_DATA;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_DATA: begin
          if (bit_done) begin
            tcnt <= '0;
            sh   <= sh >> 1;
            if (bit_idx == last_idx_q) ph <= par_en_q ? PH_PARITY : PH_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_PARITY: begin
          if (bit_done) begin
            tcnt <= '0;
            ph   <= PH_STOP;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_STOP: begin
          if (tick && tcnt == stop_last_q) begin
            tcnt <= '0;
            ph   <= PH_IDLE;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assert_bit_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph inside {PH_START, PH_DATA, PH_PARITY}) |-> tcnt <= LAST_BIT);
  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && ph != PH_IDLE) |=> ($stable(ph) && $stable(tcnt)));
  assert_stop_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STOP) |-> tcnt <= stop_last_q);
  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |=> ($stable(last_idx_q) && $stable(stop_last_q) && $stable(par_en_q)));
  assert_break_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && ph == PH_IDLE) |=> ph == PH_IDLE);

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
  parameter int FIFO_DEPTH    = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic [1:0] char_len,
  input  logic [1:0] parity_mode,
  input  logic       stop_long,
  input  logic       brk_req,
  output logic       txd,
  output logic       busy,
  output logic       fifo_empty,
  output logic       overflow
);
  logic [7:0] head;
  logic       pop, line;

  stx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (in_valid),
    .push_data  (in_data),
    .push_ready (in_ready),
    .pop        (pop),
    .head       (head),
    .empty      (fifo_empty),
    .ovf        (overflow)
  );

  stx_framer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick16),
    .brk         (brk_req),
    .char_len    (char_len),
    .parity_mode (parity_mode),
    .stop_long   (stop_long),
    .head        (head),
    .empty       (fifo_empty),
    .pop         (pop),
    .line        (line),
    .busy        (busy)
  );

  assign txd = line & ~brk_req;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk_req) |-> txd);
  assert_start_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !fifo_empty && !brk_req) |=> busy);

endmodule

// File: tb/tb_serial_tx_engine.sv
module tb_serial_tx_engine;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [1:0] char_len = 2'd3;
  logic [1:0] parity_mode = 2'd0;
  logic       stop_long = 1'b0;
  logic       brk_req = 1'b0;
  logic       txd, busy, fifo_empty, overflow;

  serial_tx_engine dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .char_len(char_len),
    .parity_mode(parity_mode), .stop_long(stop_long), .brk_req(brk_req),
    .txd(txd), .busy(busy), .fifo_empty(fifo_empty), .overflow(overflow)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit running = 1'b0;

  // Behavioural reference: queue of bytes and a frame described by integers.
  int q[$];
  int m_ph = 0, m_tc = 0, m_bi = 0, m_nb = 8, m_sh = 0, m_pen = 0, m_pb = 0, m_stl = 16, m_ovf = 0;

  task automatic model_step();
    bit do_pop, accept;
    int ones;
    if (!rst_n) begin
      q.delete(); m_ph = 0; m_tc = 0; m_ovf = 0;
      return;
    end
    do_pop = (m_ph == 0) && (q.size() > 0) && !brk_req;
    accept = in_valid && (q.size() < DEPTH);
    if (in_valid && q.size() >= DEPTH) m_ovf = 1;
    case (m_ph)
      0: if (do_pop) begin
        m_nb  = 5 + int'(char_len);
        m_sh  = q[0] & ((1 << m_nb) - 1);
        m_pen = (parity_mode == 2'd1 || parity_mode == 2'd2);
        ones  = $countones(m_sh);
        m_pb  = (parity_mode == 2'd1) ? (ones % 2) : (1 - ones % 2);
        m_stl = stop_long ? ((char_len == 2'd0) ? 24 : 32) : 16;
        m_ph = 1; m_tc = 0;
      end
      1: if (tick16) begin
        if (m_tc == 15) begin m_tc = 0; m_ph = 2; m_bi = 0; end else m_tc++;
      end
      2: if (tick16) begin
        if (m_tc == 15) begin
          m_tc = 0; m_sh = m_sh >> 1;
          if (m_bi == m_nb - 1) m_ph = m_pen ? 3 : 4; else m_bi++;
        end else m_tc++;
      end
      3: if (tick16) begin
        if (m_tc == 15) begin m_tc = 0; m_ph = 4; end else m_tc++;
      end
      default: if (tick16) begin
        if (m_tc == m_stl - 1) begin m_tc = 0; m_ph = 0; end else m_tc++;
      end
    endcase
    if (accept) q.push_back(int'(in_data));
    if (do_pop) void'(q.pop_front());
  endtask

  always @(posedge clk) model_step();

  always @(negedge clk) tick16 <= ($urandom_range(0, 3) != 0);

  task automatic check1(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d at %0t", req, tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_line();
    int l;
    case (m_ph)
      1: l = 0;
      2: l = m_sh & 1;
      3: l = m_pb;
      default: l = 1;
    endcase
    return brk_req ? 0 : l;
  endfunction

  always @(negedge clk) begin
    #1;
    if (running && rst_n) begin
      check1("R2", "txd", int'(txd), exp_line());
      check1("R10", "busy", int'(busy), int'(m_ph != 0));
      check1("R10", "fifo_empty", int'(fifo_empty), int'(q.size() == 0));
      check1("R7", "in_ready", int'(in_ready), int'(q.size() < DEPTH));
      check1("R8", "overflow", int'(overflow), m_ovf);
    end
  end

  task automatic burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'(base + 37 * i);
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && !(q.size() == 0 && m_ph == 0); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000 - 1000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    check1("R1", "reset txd", int'(txd), 1);
    check1("R1", "reset busy", int'(busy), 0);
    check1("R1", "reset empty", int'(fifo_empty), 1);
    check1("R1", "reset ready", int'(in_ready), 1);
    check1("R1", "reset overflow", int'(overflow), 0);
    @(negedge clk); rst_n = 1'b1; running = 1'b1;
    repeat (20) @(negedge clk);

    // R2 R3 R4 R5: every length, parity and stop setting
    tag = "R2 R3 R4 R5";
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          char_len = 2'(l); parity_mode = 2'(p); stop_long = 1'(s);
          burst(1, 8'hA5 + 11 * l + 3 * p + s);
          wait_idle();
        end
    @(negedge clk); parity_mode = 2'd3;
    burst(1, 8'h5C);
    wait_idle();

    // R6: settings changed mid-frame do not affect it
    tag = "R6";
    @(negedge clk); char_len = 2'd0; parity_mode = 2'd1; stop_long = 1'b1;
    burst(2, 8'h3B);
    repeat (60) @(negedge clk);
    char_len = 2'd3; parity_mode = 2'd2; stop_long = 1'b0;
    wait_idle();

    // R7 R8 R11: over-full burst, back-to-back frames
    tag = "R7 R8 R11";
    @(negedge clk); char_len = 2'd0; parity_mode = 2'd0; stop_long = 1'b0;
    burst(20, 8'h10);
    #1;
    check1("R8", "overflow after full burst", int'(overflow), 1);
    check1("R7", "ready low when full", int'(in_ready), 0);
    wait_idle();
    #1;
    check1("R8", "overflow sticky", int'(overflow), 1);

    // R9: break at idle holds queue, then mid-frame
    tag = "R9";
    @(negedge clk); brk_req = 1'b1;
    burst(3, 8'hC3);
    repeat (300) @(negedge clk);
    #1;
    check1("R9", "queue kept during break", int'(fifo_empty), 0);
    check1("R9", "no frame during break", int'(busy), 0);
    check1("R9", "line low in break", int'(txd), 0);
    @(negedge clk); brk_req = 1'b0;
    wait_idle();
    burst(1, 8'h96);
    repeat (50) @(negedge clk);
    brk_req = 1'b1;
    repeat (60) @(negedge clk);
    brk_req = 1'b0;
    wait_idle();

    // R10 R11: mixed stream with 1.5 stop bits
    tag = "R10 R11";
    @(negedge clk); char_len = 2'd0; parity_mode = 2'd2; stop_long = 1'b1;
    burst(5, 8'h07);
    wait_idle();

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule